// File: doc/BRIEF.md
# Rational-ratio polyphase FIR resampler

This block changes the sample rate of a stream of signed fixed-point samples by the rational factor L/M. It raises the rate by L and lowers it by M in one step. The default is L = 5 and M = 3, so five results come out for every three samples taken in. Conceptually the input is zero-stuffed by L, passed through a prototype low-pass FIR of L·N taps, and then only every M-th sample is kept. The hardware computes only the kept samples. It stores the prototype as L phases of N taps. For each result it picks the phase (n·M) mod L and takes one full dot product against an N-deep sample delay line.

The processing clock must run at ceil(L/M) times the input sample rate. For the default this is 2, so a new sample may be offered at most every other cycle. A sample is offered by holding `samp_en` high for one cycle. Each taken sample is echoed on `samp_taken` so that the producer can pace itself. Results appear on `y_out` together with a one-cycle `y_en` strobe. The strobe pattern is irregular (for 5/3 it is two results, two results, then one result, and so on), so a downstream rate-smoothing FIFO is expected.

Top module: `poly_resampler`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line and the phase state, and holds `y_en`, `samp_taken` and `y_out` at 0. After reset no result appears until a sample is taken, and samples taken before the reset have no influence on later results.
- R2: `samp_taken` is high for exactly one cycle, in the cycle after the clock edge at which `samp_en` was sampled high. There is one pulse per taken sample and none otherwise.
- R3: Result n (counted from reset, starting at 0) uses phase p = (n·M) mod L and input index k = floor(n·M/L). Its value is the sum over j = 0..N-1 of COEF[p + j·L]·x[k−j], with x of a negative index taken as 0. This equals zero-stuffing x by L, filtering with COEF[0..L·N−1] and keeping every M-th sample.
- R4: Once K samples have been taken and the pending results have been delivered, exactly ceil(K·L/M) results have been delivered. With the defaults this is five results for every three samples.
- R5: At most one result is delivered per clock, each marked by a single `y_en` cycle. When L ≥ M, the first result that depends on a newly taken sample is delivered in the cycle right after its `samp_taken` pulse, and any further results follow in the cycles after that.
- R6: The full-precision sum (Q30 for Q15 data and Q15 coefficients) is rounded by adding 2^14 and shifting right arithmetically by 15. It is then clamped to the 16-bit range −32768..32767.
- R7: `y_out` keeps its value in every cycle where `y_en` is low. The delay line advances only on taken samples, so idle cycles between samples do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock, ceil(L/M) times the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Input sample qualifier; high for one cycle per sample |
| samp_in | input | DW (16) | Signed input sample, Q15 |
| samp_taken | output | 1 | One-cycle echo marking that a sample was taken |
| y_out | output | DW (16) | Signed resampled result, Q15, rounded and saturated |
| y_en | output | 1 | One-cycle qualifier for `y_out` |

## Verification
The timing and credit assertions assume that the producer keeps at least ceil(L/M) cycles between two `samp_en` pulses. Each sample must therefore have delivered all of its results before the next one shifts the delay line. Under that spacing the credit of L per taken sample, less M per result, always stays between −M and L. The stimulus keeps to this spacing by using a gap of two cycles for the default ratio. The irregular-gap run only ever widens that gap, never narrows it. Reset is applied between runs, and once in the middle of a stream, so that the reset assertion and the cleared history are both exercised.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DEF_L  = 5;
    localparam int DEF_M  = 3;
    localparam int DEF_N  = 4;
    localparam int DEF_DW = 16;
    localparam int DEF_CF = 15;

    typedef logic signed [15:0] coef_t;
    typedef logic signed [63:0] wide_t;

    // prototype low-pass, index i = phase + tap * L
    localparam coef_t DEF_COEF [DEF_L*DEF_N] = '{
        -16'sd400,  -16'sd1200, -16'sd1800, -16'sd1400,  16'sd0,
         16'sd3600,  16'sd9000,  16'sd16000, 16'sd23000, 16'sd32000,
         16'sd32000, 16'sd23000, 16'sd16000, 16'sd9000,  16'sd3600,
         16'sd0,    -16'sd1400, -16'sd1800, -16'sd1200, -16'sd400
    };

    // round half up by sh bits, then clamp to an ow-bit signed range
    function automatic wide_t round_sat(wide_t a, int unsigned sh, int unsigned ow);
        wide_t r;
        wide_t hi;
        wide_t lo;
        hi = (64'sd1 <<< (ow - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (ow - 1));
        if (sh == 0) r = a;
        else         r = (a + (64'sd1 <<< (sh - 1))) >>> sh;
        if (r > hi)      r = hi;
        else if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl #(
    parameter int L  = rs_pkg::DEF_L,
    parameter int M  = rs_pkg::DEF_M,
    parameter int PW = $clog2(L + M + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    output logic          fire,
    output logic [PW-1:0] phase
);

    localparam logic [PW-1:0] L_W = PW'(L);
    localparam logic [PW-1:0] M_W = PW'(M);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_d;

    // ph_q holds n*M - k*L for the next result n and the newest sample k
    assign fire  = (ph_q < L_W);
    assign phase = fire ? ph_q : '0;

    always_comb begin
        ph_d = ph_q;
        if (fire)   ph_d = ph_d + M_W;
        if (accept) ph_d = ph_d - L_W;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= L_W;
        else     ph_q <= ph_d;
    end

endmodule

// File: rtl/rs_tapline.sv
module rs_tapline #(
    parameter int N  = rs_pkg::DEF_N,
    parameter int DW = rs_pkg::DEF_DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [N]
);

    logic signed [DW-1:0] tap_q [N];

    always_ff @(posedge clk) begin
        if (rst)        tap_q[0] <= '0;
        else if (shift) tap_q[0] <= din;
    end

    for (genvar j = 1; j < N; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)        tap_q[j] <= '0;
            else if (shift) tap_q[j] <= tap_q[j-1];
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        assign taps[j] = tap_q[j];
    end

endmodule

// File: rtl/rs_mac.sv
module rs_mac #(
    parameter int L  = rs_pkg::DEF_L,
    parameter int N  = rs_pkg::DEF_N,
    parameter int DW = rs_pkg::DEF_DW,
    parameter int PW = 4,
    parameter int AW = 2 * DW + $clog2(N) + 1,
    parameter rs_pkg::coef_t COEF [L*N] = rs_pkg::DEF_COEF
) (
    input  logic                 [PW-1:0] phase,
    input  logic signed          [DW-1:0] taps [N],
    output logic signed          [AW-1:0] acc
);

    localparam int PRW = 2 * DW;

    logic signed [PRW-1:0] prod [N];

    for (genvar j = 0; j < N; j++) begin : g_tap
        rs_pkg::coef_t c_sel;
        always_comb begin
            c_sel = '0;
            for (int p = 0; p < L; p++) begin
                if (phase == PW'(p)) c_sel = COEF[p + j*L];
            end
        end
        assign prod[j] = PRW'(taps[j]) * PRW'(c_sel);
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < N; j++) begin
            acc = acc + AW'(prod[j]);
        end
    end

endmodule

// File: rtl/poly_resampler.sv
module poly_resampler #(
    parameter int L  = rs_pkg::DEF_L,
    parameter int M  = rs_pkg::DEF_M,
    parameter int N  = rs_pkg::DEF_N,
    parameter int DW = rs_pkg::DEF_DW,
    parameter int CF = rs_pkg::DEF_CF,
    parameter rs_pkg::coef_t COEF [L*N] = rs_pkg::DEF_COEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_en,
    input  logic signed [DW-1:0] samp_in,
    output logic                 samp_taken,
    output logic signed [DW-1:0] y_out,
    output logic                 y_en
);

    localparam int PW = $clog2(L + M + 1);
    localparam int AW = 2 * DW + $clog2(N) + 1;

    logic                 fire;
    logic [PW-1:0]        phase;
    logic signed [DW-1:0] taps [N];
    logic signed [AW-1:0] acc;
    rs_pkg::wide_t        rnd;

    logic                 taken_q;
    logic                 yen_q;
    logic signed [DW-1:0] y_q;

    rs_phase_ctrl #(.L(L), .M(M), .PW(PW)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .accept (samp_en),
        .fire   (fire),
        .phase  (phase)
    );

    rs_tapline #(.N(N), .DW(DW)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .shift (samp_en),
        .din   (samp_in),
        .taps  (taps)
    );

    rs_mac #(.L(L), .N(N), .DW(DW), .PW(PW), .AW(AW), .COEF(COEF)) u_mac (
        .phase (phase),
        .taps  (taps),
        .acc   (acc)
    );

    assign rnd = rs_pkg::round_sat(64'(acc), CF, DW);

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            yen_q   <= 1'b0;
            y_q     <= '0;
        end else begin
            taken_q <= samp_en;
            yen_q   <= fire;
            if (fire) y_q <= DW'(rnd);
        end
    end

    assign samp_taken = taken_q;
    assign y_en       = yen_q;
    assign y_out      = y_q;

endmodule

// File: rtl/poly_resampler_chk.sv
module poly_resampler_chk #(
    parameter int L  = rs_pkg::DEF_L,
    parameter int M  = rs_pkg::DEF_M,
    parameter int DW = rs_pkg::DEF_DW
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 samp_en,
    input logic                 samp_taken,
    input logic                 y_en,
    input logic signed [DW-1:0] y_out
);

    int credit;

    always_ff @(posedge clk) begin
        if (rst) credit <= 0;
        else     credit <= credit + (samp_taken ? L : 0) - (y_en ? M : 0);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!y_en && !samp_taken && y_out == '0));

    // R2
    taken_echo_chk: assert property (@(posedge clk) disable iff (rst)
        samp_taken |-> $past(samp_en));

    // R4
    credit_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (credit > -M) && (credit <= L));

    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !y_en |-> $stable(y_out));

    if (L >= M) begin : g_up
        // R5
        first_out_chk: assert property (@(posedge clk) disable iff (rst)
            samp_taken |=> y_en);
    end

endmodule

bind poly_resampler poly_resampler_chk #(.L(L), .M(M), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_en    (samp_en),
    .samp_taken (samp_taken),
    .y_en       (y_en),
    .y_out      (y_out)
);

// File: tb/poly_resampler_test.sv
module poly_resampler_test;

    localparam int L = 5;
    localparam int M = 3;
    localparam int NT = 20;
    localparam int H [NT] = '{
        -400, -1200, -1800, -1400, 0, 3600, 9000, 16000, 23000, 32000,
        32000, 23000, 16000, 9000, 3600, 0, -1400, -1800, -1200, -400
    };
    localparam int NSTIM = 24;
    localparam int STIM [NSTIM] = '{
        16384, 0, 0, 0, 0, 0,
        10000, 10000, 10000, 10000, 10000, 10000,
        -15000, -9000, -3000, 3000, 9000, 15000,
        20000, -20000, 20000, -20000, 7, -7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_en = 1'b0;
    logic [15:0] samp_in = '0;
    logic        samp_taken;
    logic [15:0] y_out;
    logic        y_en;

    int nchk = 0, nbad = 0;
    int xs [64];
    int kin = 0;
    int got [128];
    int gcnt = 0, tcnt = 0, late_err = 0, take_err = 0;
    bit prev_taken = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    poly_resampler uut (
        .clk(clk), .rst(rst), .samp_en(samp_en), .samp_in(samp_in),
        .samp_taken(samp_taken), .y_out(y_out), .y_en(y_en)
    );

    always @(negedge clk) begin
        if (rst) prev_taken = 1'b0;
        else begin
            if (y_en && gcnt < 128) begin
                got[gcnt] = int'($signed(y_out));
                gcnt++;
            end
            if (samp_taken) tcnt++;
            if (prev_taken && !y_en) late_err++;
            prev_taken = samp_taken;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_y(int n);
        longint acc = 0;
        for (int i = 0; i < NT; i++) begin
            int t = n * M - i;
            if (t >= 0 && (t % L) == 0 && (t / L) < kin)
                acc += longint'(H[i]) * longint'(xs[t / L]);
        end
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        samp_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        check(y_en == 1'b0 && samp_taken == 1'b0, "R1 strobes in reset", {y_en, samp_taken}, 0);
        check(y_out == 16'd0, "R1 y_out in reset", y_out, 0);
        rst = 1'b0;
        kin = 0; gcnt = 0; tcnt = 0; late_err = 0; take_err = 0;
    endtask

    task automatic send(input int v, input int gap);
        samp_en = 1'b1;
        samp_in = 16'(v);
        @(negedge clk);
        samp_en = 1'b0;
        if (samp_taken !== 1'b1) take_err++;
        xs[kin] = v;
        kin++;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic check_seg(input string tag);
        int expn;
        repeat (6) @(negedge clk);
        expn = (kin * L + M - 1) / M;
        // R4: result count
        check(gcnt == expn, {"R4 count ", tag}, gcnt, expn);
        // R2: one echo per sample, in the following cycle
        check(tcnt == kin && take_err == 0, {"R2 echo ", tag}, tcnt, kin);
        // R5: first result right after echo
        check(late_err == 0, {"R5 timing ", tag}, late_err, 0);
        for (int n = 0; n < expn && n < gcnt; n++) begin
            // R3 and R6: value against zero-stuff model
            check(got[n] == model_y(n), {"R3 value ", tag}, got[n], model_y(n));
        end
    endtask

    initial begin
        do_reset();
        // R1: no result without a sample
        repeat (8) @(negedge clk);
        check(gcnt == 0 && tcnt == 0, "R1 idle after reset", gcnt, 0);

        for (int i = 0; i < NSTIM; i++) send(STIM[i], 2);
        check_seg("table");

        // R6: saturation at both rails
        do_reset();
        for (int i = 0; i < 8; i++) send(32767, 2);
        for (int i = 0; i < 8; i++) send(-32768, 2);
        check_seg("sat");
        begin
            int mx = -100000, mn = 100000;
            for (int n = 0; n < gcnt; n++) begin
                if (got[n] > mx) mx = got[n];
                if (got[n] < mn) mn = got[n];
            end
            check(mx == 32767, "R6 clamp high", mx, 32767);
            check(mn == -32768, "R6 clamp low", mn, -32768);
        end

        // R7: irregular idle gaps leave values unchanged
        do_reset();
        begin
            int gaps [10] = '{2, 3, 5, 2, 7, 4, 2, 2, 9, 3};
            for (int i = 0; i < 10; i++) send(3000 * (i + 1) - 14000, gaps[i]);
        end
        check_seg("gaps");

        // R1: reset mid-stream wipes history; R4: five for three
        do_reset();
        for (int i = 0; i < 4; i++) send(25000, 2);
        do_reset();
        repeat (5) @(negedge clk);
        check(gcnt == 0, "R1 no output after mid reset", gcnt, 0);
        send(-12000, 2);
        send(30000, 2);
        send(5000, 2);
        check_seg("restart");
        check(gcnt == 5, "R4 five per three", gcnt, 5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule